// File: doc/BRIEF.md
# RX Flow-Control Frame Classifier

This block sits behind the receive header parser of an Ethernet MAC. For every parsed frame header, presented for one cycle with a valid strobe, it decides whether the frame is a flow-control frame that local logic must act on, or one that goes on to the user like any other frame. The block takes the destination address, EtherType, MAC-control opcode, class-enable vector and the per-class pause quanta as inputs. Configuration comes from an external register bank as plain inputs: a programmable 48-bit station address split into a 32-bit low word and a 16-bit high word, a per-class priority pause enable and a single enable for acting on classic pause.

An accepted classic pause frame raises a one-cycle stop-transmit pulse together with its quanta. An accepted priority (per-class) pause frame raises a one-cycle valid pulse, a 16-bit quanta and a resume flag for each class it acts on. Any frame that is not acted on raises a one-cycle forward pulse, and no flow-control indicator. This covers frames with no address match, other EtherTypes, unknown opcodes and disabled functions. Each header gives exactly one outcome, one clock after it is presented.

Top module: `rx_fc_classify`

## Requirements
- R1: While `rst_n` is low, and in the first cycle after it is released, `fwd_valid`, `stop_valid`, `pfc_valid` and `pfc_xon` are all zero.
- R2: A frame is considered only if `hdr_dst` equals `{cfg_dst_hi, cfg_dst_lo}` or the multicast address 48'h0180C2000001. The first byte on the wire is in bits 47:40. Any other destination is forwarded.
- R3: A frame is considered only if `hdr_etype` equals 16'h8808. Any other EtherType is forwarded.
- R4: A considered frame with opcode 16'h0001 and `cfg_pause_stop_en`=1 raises `stop_valid` for one cycle. `stop_quanta` then equals quanta slot 0 (`hdr_quanta[15:0]`), and `fwd_valid` stays low.
- R5: A considered frame with opcode 16'h0001 and `cfg_pause_stop_en`=0 is forwarded, and `stop_valid` stays low.
- R6: For a considered frame with opcode 16'h0101, class k fires only if `hdr_cls_vec[k]` and `cfg_pfc_en[k]` are both 1. Each firing class gets `pfc_valid[k]`=1 for one cycle, and its quanta slot `hdr_quanta[16k+15:16k]` appears on the same slice of `pfc_quanta`.
- R7: A zero quanta means resume. `stop_resume` is 1 with `stop_valid` when the quanta is zero, and `pfc_xon[k]` is 1 with `pfc_valid[k]` when slot k is zero. Otherwise both are 0.
- R8: A priority pause frame in which no class fires is forwarded, and `pfc_valid` stays zero.
- R9: A considered frame with any opcode other than 16'h0001 or 16'h0101 is forwarded with no indicator.
- R10: Outputs appear exactly one clock after `hdr_valid`. Each is a single-cycle pulse per header, and no output pulses in a cycle whose previous cycle had `hdr_valid` low.
- R11: Every header gives exactly one of: `fwd_valid`, `stop_valid`, or one or more `pfc_valid` bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| hdr_valid | input | 1 | Header strobe, one cycle per frame |
| hdr_dst | input | 48 | Destination address, first wire byte in MSBs |
| hdr_etype | input | 16 | EtherType |
| hdr_opcode | input | 16 | MAC-control opcode |
| hdr_cls_vec | input | NCLS | Class-enable vector carried in the frame |
| hdr_quanta | input | NCLS*QW | Quanta slots, slot k in bits 16k+15:16k |
| cfg_dst_lo | input | 32 | Programmed address, low 32 bits |
| cfg_dst_hi | input | 16 | Programmed address, high 16 bits |
| cfg_pfc_en | input | NCLS | Local per-class enable |
| cfg_pause_stop_en | input | 1 | Act on classic pause frames |
| fwd_valid | output | 1 | Frame goes to the user as data |
| stop_valid | output | 1 | Stop-transmit request pulse |
| stop_quanta | output | QW | Quanta of the stop request |
| stop_resume | output | 1 | Stop request carries zero quanta |
| pfc_valid | output | NCLS | Per-class pause pulse |
| pfc_quanta | output | NCLS*QW | Per-class pause quanta |
| pfc_xon | output | NCLS | Per-class resume flag |

## Verification
The classifier is driven with headers that differ in one field at a time from an accepted frame. A frame is sent to the multicast address and to the programmed address, and then to an address one bit away from the programmed one. The EtherType and the opcode are each altered while the other fields stay unchanged. This shows that each comparator gates acceptance on its own. Priority pause frames pair different frame class vectors with different local enables, including disjoint ones. This separates AND gating from either operand alone, and it shows the fallback to forwarding when no class fires. Zero quanta in selected slots, back-to-back headers and a reset asserted with a header pending check the resume flags and the pulse timing.

// File: rtl/rx_fc_classify.sv
module rx_fc_classify #(
  parameter int          NCLS      = 8,
  parameter int          QW        = 16,
  parameter logic [47:0] MCAST_DA  = 48'h0180C2000001,
  parameter logic [15:0] FC_ETYPE  = 16'h8808,
  parameter logic [15:0] OP_PAUSE  = 16'h0001,
  parameter logic [15:0] OP_PFC    = 16'h0101
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 hdr_valid,
  input  logic [47:0]          hdr_dst,
  input  logic [15:0]          hdr_etype,
  input  logic [15:0]          hdr_opcode,
  input  logic [NCLS-1:0]      hdr_cls_vec,
  input  logic [NCLS*QW-1:0]   hdr_quanta,
  input  logic [31:0]          cfg_dst_lo,
  input  logic [15:0]          cfg_dst_hi,
  input  logic [NCLS-1:0]      cfg_pfc_en,
  input  logic                 cfg_pause_stop_en,
  output logic                 fwd_valid,
  output logic                 stop_valid,
  output logic [QW-1:0]        stop_quanta,
  output logic                 stop_resume,
  output logic [NCLS-1:0]      pfc_valid,
  output logic [NCLS*QW-1:0]   pfc_quanta,
  output logic [NCLS-1:0]      pfc_xon
);

  logic            da_hit, fc_hit, take_pause, take_any;
  logic [NCLS-1:0] fire, zq;

  assign da_hit     = (hdr_dst == {cfg_dst_hi, cfg_dst_lo}) || (hdr_dst == MCAST_DA);
  assign fc_hit     = da_hit && (hdr_etype == FC_ETYPE);
  assign take_pause = fc_hit && (hdr_opcode == OP_PAUSE) && cfg_pause_stop_en;
  assign take_any   = take_pause || (|fire);

  for (genvar k = 0; k < NCLS; k++) begin : g_cls
    logic [QW-1:0] slot;
    assign slot    = hdr_quanta[k*QW +: QW];
    assign zq[k]   = (slot == '0);
    assign fire[k] = fc_hit && (hdr_opcode == OP_PFC) && hdr_cls_vec[k] && cfg_pfc_en[k];

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        pfc_quanta[k*QW +: QW] <= '0;
      else if (hdr_valid && fire[k])
        pfc_quanta[k*QW +: QW] <= slot;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fwd_valid   <= 1'b0;
      stop_valid  <= 1'b0;
      stop_quanta <= '0;
      stop_resume <= 1'b0;
      pfc_valid   <= '0;
      pfc_xon     <= '0;
    end else begin
      fwd_valid   <= hdr_valid && !take_any;
      stop_valid  <= hdr_valid && take_pause;
      stop_resume <= hdr_valid && take_pause && zq[0];
      pfc_valid   <= hdr_valid ? fire : '0;
      pfc_xon     <= hdr_valid ? (fire & zq) : '0;
      if (hdr_valid && take_pause)
        stop_quanta <= hdr_quanta[QW-1:0];
    end
  end

endmodule

module rx_fc_classify_chk #(
  parameter int          NCLS     = 8,
  parameter logic [47:0] MCAST_DA = 48'h0180C2000001,
  parameter logic [15:0] FC_ETYPE = 16'h8808,
  parameter logic [15:0] OP_PAUSE = 16'h0001,
  parameter logic [15:0] OP_PFC   = 16'h0101
) (
  input logic            clk,
  input logic            rst_n,
  input logic            hdr_valid,
  input logic [47:0]     hdr_dst,
  input logic [15:0]     hdr_etype,
  input logic [15:0]     hdr_opcode,
  input logic [NCLS-1:0] hdr_cls_vec,
  input logic [31:0]     cfg_dst_lo,
  input logic [15:0]     cfg_dst_hi,
  input logic [NCLS-1:0] cfg_pfc_en,
  input logic            cfg_pause_stop_en,
  input logic            fwd_valid,
  input logic            stop_valid,
  input logic [NCLS-1:0] pfc_valid,
  input logic [NCLS-1:0] pfc_xon
);

  AST_DA_MISS_FWD: assert property (@(posedge clk) disable iff (!rst_n)
    (hdr_valid && hdr_dst != {cfg_dst_hi, cfg_dst_lo} && hdr_dst != MCAST_DA) |=> fwd_valid); // R2

  AST_ETYPE_FWD: assert property (@(posedge clk) disable iff (!rst_n)
    (hdr_valid && hdr_etype != FC_ETYPE) |=> fwd_valid); // R3

  AST_STOP_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    stop_valid |-> $past(cfg_pause_stop_en)); // R5

  AST_PFC_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    hdr_valid |=> ((pfc_valid & ~($past(hdr_cls_vec) & $past(cfg_pfc_en))) == '0)); // R6

  AST_XON_SUBSET: assert property (@(posedge clk) disable iff (!rst_n)
    ((pfc_xon & ~pfc_valid) == '0)); // R7

  AST_BAD_OP_FWD: assert property (@(posedge clk) disable iff (!rst_n)
    (hdr_valid && hdr_opcode != OP_PAUSE && hdr_opcode != OP_PFC) |=> fwd_valid); // R9

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !hdr_valid |=> !(fwd_valid || stop_valid || (|pfc_valid))); // R10

  AST_ONE_OUTCOME: assert property (@(posedge clk) disable iff (!rst_n)
    hdr_valid |=> (fwd_valid || stop_valid || (|pfc_valid))); // R11

  AST_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({fwd_valid, stop_valid, |pfc_valid})); // R11

endmodule

bind rx_fc_classify rx_fc_classify_chk #(
  .NCLS(NCLS), .MCAST_DA(MCAST_DA), .FC_ETYPE(FC_ETYPE), .OP_PAUSE(OP_PAUSE), .OP_PFC(OP_PFC)
) u_chk (
  .clk(clk), .rst_n(rst_n), .hdr_valid(hdr_valid), .hdr_dst(hdr_dst),
  .hdr_etype(hdr_etype), .hdr_opcode(hdr_opcode), .hdr_cls_vec(hdr_cls_vec),
  .cfg_dst_lo(cfg_dst_lo), .cfg_dst_hi(cfg_dst_hi), .cfg_pfc_en(cfg_pfc_en),
  .cfg_pause_stop_en(cfg_pause_stop_en), .fwd_valid(fwd_valid), .stop_valid(stop_valid),
  .pfc_valid(pfc_valid), .pfc_xon(pfc_xon)
);

// File: tb/sim_rx_fc_classify.sv
module sim_rx_fc_classify;
  localparam int NCLS = 8;
  localparam int QW   = 16;
  localparam logic [47:0] MC   = 48'h0180C2000001;
  localparam logic [47:0] PROG = 48'h0A1B2C3D4E5F;

  typedef struct packed {
    logic [47:0] dst;
    logic [15:0] et;
    logic [15:0] op;
    logic [7:0]  vec;
    logic [15:0] base;
    logic [7:0]  zmask;
    logic [7:0]  pen;
    logic        sen;
    logic        e_fwd;
    logic        e_stop;
    logic [7:0]  e_pfc;
  } vec_t;

  localparam int NV = 14;
  localparam vec_t TBL [NV] = '{
    '{MC,   16'h8808, 16'h0001, 8'h00, 16'h1200, 8'h00, 8'hFF, 1'b1, 1'b0, 1'b1, 8'h00}, // R4
    '{PROG, 16'h8808, 16'h0001, 8'h00, 16'h0040, 8'h00, 8'hFF, 1'b1, 1'b0, 1'b1, 8'h00}, // R2
    '{48'h0A1B2C3D4E5E, 16'h8808, 16'h0001, 8'h00, 16'h0040, 8'h00, 8'hFF, 1'b1, 1'b1, 1'b0, 8'h00}, // R2
    '{48'h0180C2000002, 16'h8808, 16'h0101, 8'hFF, 16'h0040, 8'h00, 8'hFF, 1'b1, 1'b1, 1'b0, 8'h00}, // R2
    '{MC,   16'h0800, 16'h0001, 8'h00, 16'h0040, 8'h00, 8'hFF, 1'b1, 1'b1, 1'b0, 8'h00}, // R3
    '{MC,   16'h8809, 16'h0101, 8'hFF, 16'h0040, 8'h00, 8'hFF, 1'b1, 1'b1, 1'b0, 8'h00}, // R3
    '{MC,   16'h8808, 16'h0001, 8'h00, 16'h0040, 8'h00, 8'hFF, 1'b0, 1'b1, 1'b0, 8'h00}, // R5
    '{MC,   16'h8808, 16'h0101, 8'hA5, 16'h0300, 8'h00, 8'hFF, 1'b0, 1'b0, 1'b0, 8'hA5}, // R6
    '{MC,   16'h8808, 16'h0101, 8'hFF, 16'h0700, 8'h00, 8'h0F, 1'b1, 1'b0, 1'b0, 8'h0F}, // R6
    '{PROG, 16'h8808, 16'h0101, 8'h3C, 16'hBEE0, 8'h00, 8'h3C, 1'b1, 1'b0, 1'b0, 8'h3C}, // R6
    '{MC,   16'h8808, 16'h0101, 8'hF0, 16'h0040, 8'h00, 8'h0F, 1'b1, 1'b1, 1'b0, 8'h00}, // R8
    '{MC,   16'h8808, 16'h0002, 8'hFF, 16'h0040, 8'h00, 8'hFF, 1'b1, 1'b1, 1'b0, 8'h00}, // R9
    '{MC,   16'h8808, 16'h0101, 8'h81, 16'h0500, 8'h81, 8'hFF, 1'b1, 1'b0, 1'b0, 8'h81}, // R7
    '{MC,   16'h8808, 16'h0001, 8'h00, 16'h0900, 8'h01, 8'hFF, 1'b1, 1'b0, 1'b1, 8'h00}  // R7
  };

  logic clk = 1'b0, rst_n = 1'b0;
  logic hdr_valid = 1'b0;
  logic [47:0] hdr_dst = '0;
  logic [15:0] hdr_etype = '0, hdr_opcode = '0;
  logic [NCLS-1:0] hdr_cls_vec = '0;
  logic [NCLS*QW-1:0] hdr_quanta = '0;
  logic [31:0] cfg_dst_lo = PROG[31:0];
  logic [15:0] cfg_dst_hi = PROG[47:32];
  logic [NCLS-1:0] cfg_pfc_en = '1;
  logic cfg_pause_stop_en = 1'b0;
  logic fwd_valid, stop_valid, stop_resume;
  logic [QW-1:0] stop_quanta;
  logic [NCLS-1:0] pfc_valid, pfc_xon;
  logic [NCLS*QW-1:0] pfc_quanta;

  int n_chk = 0, n_bad = 0;

  always #2.5 clk = ~clk;

  rx_fc_classify #(.NCLS(NCLS), .QW(QW)) u0 (.*);

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [15:0] slotv(input logic [15:0] base, input logic [7:0] zm, input int k);
    return zm[k] ? 16'h0 : base + 16'(k);
  endfunction

  task automatic check_idle(input string tag);
    chk(!fwd_valid && !stop_valid && pfc_valid == '0 && pfc_xon == '0, tag,
        {fwd_valid, stop_valid, pfc_valid, pfc_xon}, 0);
  endtask

  task automatic load(input vec_t v);
    hdr_dst = v.dst; hdr_etype = v.et; hdr_opcode = v.op; hdr_cls_vec = v.vec;
    for (int k = 0; k < NCLS; k++) hdr_quanta[k*QW +: QW] = slotv(v.base, v.zmask, k);
    cfg_pfc_en = v.pen; cfg_pause_stop_en = v.sen;
  endtask

  task automatic check_out(input vec_t v, input string tag);
    chk(fwd_valid == v.e_fwd, {tag, " fwd"}, 64'(fwd_valid), 64'(v.e_fwd));
    chk(stop_valid == v.e_stop, {tag, " stop"}, 64'(stop_valid), 64'(v.e_stop));
    chk(pfc_valid == v.e_pfc, {tag, " pfc_valid"}, 64'(pfc_valid), 64'(v.e_pfc));
    if (v.e_stop) begin
      chk(stop_quanta == slotv(v.base, v.zmask, 0), "R4 stop_quanta", 64'(stop_quanta), 64'(slotv(v.base, v.zmask, 0)));
      chk(stop_resume == v.zmask[0], "R7 stop_resume", 64'(stop_resume), 64'(v.zmask[0]));
    end
    chk(pfc_xon == (v.e_pfc & v.zmask), "R7 pfc_xon", 64'(pfc_xon), 64'(v.e_pfc & v.zmask));
    for (int k = 0; k < NCLS; k++)
      if (v.e_pfc[k])
        chk(pfc_quanta[k*QW +: QW] == slotv(v.base, v.zmask, k), "R6 pfc_quanta",
            64'(pfc_quanta[k*QW +: QW]), 64'(slotv(v.base, v.zmask, k)));
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check_idle("R1 in reset");
    rst_n = 1'b1;
    @(negedge clk);
    check_idle("R1 after reset");

    for (int i = 0; i < NV; i++) begin
      load(TBL[i]);
      hdr_valid = 1'b1;
      @(negedge clk);
      hdr_valid = 1'b0;
      check_out(TBL[i], $sformatf("vec%0d R2/R3/R4/R5/R6/R8/R9", i));
      @(negedge clk);
      check_idle("R10 single pulse");
    end

    // R10: back-to-back headers, each outcome one cycle later
    load(TBL[0]);
    hdr_valid = 1'b1;
    @(negedge clk);
    load(TBL[7]);
    chk(stop_valid && !fwd_valid, "R10 b2b first", 64'({stop_valid, fwd_valid}), 64'h2);
    @(negedge clk);
    load(TBL[11]);
    chk(pfc_valid == 8'hA5 && !stop_valid, "R10 b2b second", 64'(pfc_valid), 64'hA5);
    @(negedge clk);
    hdr_valid = 1'b0;
    chk(fwd_valid && pfc_valid == '0, "R10 b2b third", 64'({fwd_valid, pfc_valid}), 64'h100);
    @(negedge clk);
    check_idle("R10 after b2b");

    // R1: reset with a header pending
    load(TBL[7]);
    hdr_valid = 1'b1;
    rst_n = 1'b0;
    @(negedge clk);
    check_idle("R1 reset with header");
    hdr_valid = 1'b0;
    rst_n = 1'b1;
    @(negedge clk);
    check_idle("R1 released");

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule